// File: doc/BRIEF.md
# Streaming CRC-32 Appender

This stage sits near the end of a packet segmentation pipeline. It takes a byte stream that has already been padded and given its trailer, and passes every byte on through a four-entry delay buffer. While the bytes go through, it folds every byte that is not marked as padding into a running CRC-32. Padding bytes still pass through, but they leave the checksum unchanged.

The upstream stage pulses a done-trailer strobe once the last trailer byte has been offered. The appender then stops accepting input and drains its buffer. After that it emits the four checksum bytes, most significant first, and pulses a done-CRC strobe for one cycle. A checksum register restarts from all ones for every packet.

Both data paths use valid/ready handshakes. A byte moves when valid and ready are both high at a rising clock edge. A sender holding valid must keep the byte steady until it is taken. The receiver may hold ready low for any length of time, and the block then freezes its output byte. The done strobes are plain single-cycle pins.

Top module: `crc_appender`

## Requirements
- R1: An output byte transfers when out_valid and out_ready are both high at a clock edge. While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R2: During a packet body, a byte reaches the output only once the delay buffer holds four bytes. After three bytes are accepted with no done-trailer, out_valid stays low.
- R3: The buffer never holds more than four bytes. When it is full, in_ready is low unless a byte leaves in the same cycle.
- R4: The checksum is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. Each byte is fed most significant bit first, with no reflection, and the final value is inverted. The ASCII bytes "123456789" give 0xFC891918.
- R5: A byte accepted with in_pad high is output unchanged and in its place in the stream, but it does not alter the checksum.
- R6: A trailer_done pulse while input is open ends the packet. A byte accepted in that same cycle belongs to the packet. From the next cycle, in_ready stays low until crc_done.
- R7: Every buffered byte is output before the first checksum byte. The four checksum bytes follow in order from bits 31:24 down to bits 7:0.
- R8: crc_done is high for exactly one cycle: the cycle after the fourth checksum byte transfers.
- R9: The checksum restarts from 0xFFFFFFFF for each packet. A packet with no unpadded bytes, empty or all padding, gets checksum 0x00000000.
- R10: A trailer_done pulse while the block is draining or appending has no effect. Exactly four checksum bytes follow each packet.
- R11: During and right after reset, out_valid is low, in_ready is high and crc_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can take the offered byte |
| in_data | input | 8 | Input byte |
| in_pad | input | 1 | Input byte is padding and is excluded from the checksum |
| trailer_done | input | 1 | One-cycle strobe: the packet and its trailer are complete |
| out_valid | output | 1 | Output byte is offered |
| out_ready | input | 1 | Downstream takes the offered byte |
| out_data | output | 8 | Output byte, data or checksum |
| crc_done | output | 1 | One-cycle strobe after the last checksum byte leaves |

## Verification
The bench compares the output stream with the known check value for "123456789". It also tries an empty packet and a packet made only of padding, where a block that hashed padding or skipped the restart would give a nonzero checksum. It sends short packets that never fill the buffer, to catch a block that appends the checksum before the held bytes have left, and it stalls the output in mid-packet. A second trailer_done pulse is sent during drain and append, where a block that obeyed it would emit extra checksum bytes. It also checks that nothing comes out before four bytes are held.

// File: rtl/crc_app_pkg.sv
package crc_app_pkg;

  // Phases of one packet: accepting data, emptying the delay buffer,
  // sending the checksum bytes.
  typedef enum logic [1:0] {
    ST_PASS   = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_APPEND = 2'd2
  } app_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/crc_app_fifo.sv
module crc_app_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/crc_app_engine.sv
module crc_app_engine #(
  parameter int               CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] INIT  = 32'hFFFFFFFF,
  parameter int               DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [DW-1:0]    din,
  input  logic             reload,
  output logic [CRC_W-1:0] crc_reg,
  output logic [CRC_W-1:0] crc_final
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] stage [DW+1];

  assign stage[0] = crc_q;

  // One shift-and-xor step per data bit, most significant data bit first.
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic fb;
    assign fb          = stage[b][CRC_W-1] ^ din[DW-1-b];
    assign stage[b+1]  = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (reload) crc_q <= INIT;
    else if (upd)    crc_q <= stage[DW];
  end

  assign crc_reg   = crc_q;
  assign crc_final = ~crc_q;

endmodule

// File: rtl/crc_app_ctrl.sv
module crc_app_ctrl
  import crc_app_pkg::*;
#(
  parameter  int FIFO_DEPTH  = 4,
  parameter  int N_CRC_BYTES = 4,
  localparam int CNT_W       = $clog2(FIFO_DEPTH + 1),
  localparam int IDX_W       = (N_CRC_BYTES > 1) ? $clog2(N_CRC_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             trailer_done,
  input  logic [CNT_W-1:0] fifo_cnt,
  output app_state_e       state,
  output logic [IDX_W-1:0] byte_idx,
  output logic             in_ready,
  output logic             out_valid,
  output logic             push,
  output logic             pop,
  output logic             crc_reload,
  output logic             crc_done
);

  app_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             full, empty, last_crc, drain_end;

  assign full  = (fifo_cnt == CNT_W'(FIFO_DEPTH));
  assign empty = (fifo_cnt == '0);

  always_comb begin
    unique case (st_q)
      ST_PASS:   out_valid = full;
      ST_DRAIN:  out_valid = !empty;
      ST_APPEND: out_valid = 1'b1;
      default:   out_valid = 1'b0;
    endcase
  end

  assign pop       = out_valid && out_ready && (st_q != ST_APPEND);
  assign in_ready  = (st_q == ST_PASS) && (!full || pop);
  assign push      = in_valid && in_ready;
  assign last_crc  = (st_q == ST_APPEND) && out_ready &&
                     (idx_q == IDX_W'(N_CRC_BYTES - 1));
  assign drain_end = empty || ((fifo_cnt == CNT_W'(1)) && pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PASS;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_crc;
      unique case (st_q)
        ST_PASS: begin
          if (trailer_done) st_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (drain_end) begin
            st_q  <= ST_APPEND;
            idx_q <= '0;
          end
        end
        ST_APPEND: begin
          if (out_ready) begin
            if (last_crc) begin
              st_q  <= ST_PASS;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: st_q <= ST_PASS;
      endcase
    end
  end

  assign state      = st_q;
  assign byte_idx   = idx_q;
  assign crc_reload = last_crc;
  assign crc_done   = done_q;

endmodule

// File: rtl/crc_appender.sv
module crc_appender
  import crc_app_pkg::*;
#(
  parameter int               CRC_W      = 32,
  parameter logic [CRC_W-1:0] POLY       = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] INIT       = 32'hFFFFFFFF,
  parameter int               FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_pad,
  input  logic       trailer_done,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       crc_done
);

  localparam int NBYTES = CRC_W / BYTE_W;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  app_state_e       state;
  logic [IDX_W-1:0] byte_idx;
  logic             push, pop, crc_reload;
  logic [CNT_W-1:0] fifo_cnt;
  logic [7:0]       fifo_rdata;
  logic [CRC_W-1:0] crc_q, crc_out;
  logic [7:0]       crc_bytes [NBYTES];

  crc_app_ctrl #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .N_CRC_BYTES(NBYTES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_ready   (out_ready),
    .trailer_done(trailer_done),
    .fifo_cnt    (fifo_cnt),
    .state       (state),
    .byte_idx    (byte_idx),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .push        (push),
    .pop         (pop),
    .crc_reload  (crc_reload),
    .crc_done    (crc_done)
  );

  crc_app_fifo #(
    .W    (BYTE_W),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .wdata(in_data),
    .pop  (pop),
    .rdata(fifo_rdata),
    .count(fifo_cnt)
  );

  crc_app_engine #(
    .CRC_W(CRC_W),
    .POLY (POLY),
    .INIT (INIT),
    .DW   (BYTE_W)
  ) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (push && !in_pad),
    .din      (in_data),
    .reload   (crc_reload),
    .crc_reg  (crc_q),
    .crc_final(crc_out)
  );

  // Checksum split into bytes, index 0 holds the most significant byte.
  for (genvar k = 0; k < NBYTES; k++) begin : g_crc_byte
    assign crc_bytes[k] = crc_out[CRC_W-1-BYTE_W*k -: BYTE_W];
  end

  assign out_data = (state == ST_APPEND) ? crc_bytes[byte_idx] : fifo_rdata;

endmodule

// File: rtl/crc_appender_chk.sv
module crc_appender_chk #(
  parameter  int FIFO_DEPTH = 4,
  parameter  int CRC_W      = 32,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_pad,
  input logic             trailer_done,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             crc_done,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic [CRC_W-1:0] crc_q
);

  // Tracks the span from an accepted trailer_done to crc_done.
  logic busy_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     busy_q <= 1'b0;
    else if (trailer_done && (!busy_q || crc_done)) busy_q <= 1'b1;
    else if (crc_done)                              busy_q <= 1'b0;
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CNT_W'(FIFO_DEPTH)) && !(out_valid && out_ready) |-> !in_ready);

  assert_pad_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_pad |=> crc_q == $past(crc_q));

  assert_input_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !crc_done |-> !in_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |=> !crc_done);

  assert_done_after_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> $past(out_valid && out_ready));

endmodule

bind crc_appender crc_appender_chk #(
  .FIFO_DEPTH(FIFO_DEPTH),
  .CRC_W     (CRC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_pad      (in_pad),
  .trailer_done(trailer_done),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .crc_done    (crc_done),
  .fifo_cnt    (fifo_cnt),
  .crc_q       (crc_q)
);

// File: tb/tb_crc_appender.sv
module tb_crc_appender;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       in_valid, in_ready, in_pad, trailer_done;
  logic [7:0] in_data;
  logic       out_valid, out_ready, crc_done;
  logic [7:0] out_data;

  crc_appender dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_pad(in_pad), .trailer_done(trailer_done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .crc_done(crc_done)
  );

  int          n_cmp = 0, n_bad = 0, n_pkts = 0, n_done = 0;
  logic [7:0]  exp_q[$];
  bit          exp_last[$];
  logic [7:0]  pkt[$];
  bit          rand_ready = 1'b0;
  bit          busy = 1'b0, prev_last = 1'b0, prev_stall = 1'b0;
  logic [7:0]  prev_data = '0;
  logic [31:0] last_word = '0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[31] ^ q[i][b];
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    return ~c;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Random back-pressure on the output.
  always @(negedge clk) if (rand_ready) out_ready <= (($urandom % 4) != 0);

  // Monitor: samples 5 ns before each rising edge.
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        if (crc_done || prev_last) check(crc_done == prev_last, "R8 done timing", crc_done, prev_last);
        if (crc_done) n_done++;
        if (busy && !crc_done) check(!in_ready, "R6 input closed", in_ready, 0);
        if (prev_stall) begin
          check(out_valid, "R1 valid held", out_valid, 1);
          check(out_data == prev_data, "R1 data held", out_data, prev_data);
        end
        prev_last  = 1'b0;
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        if (out_valid && out_ready) begin
          last_word = {last_word[23:0], out_data};
          if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected byte", out_data, 0);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            prev_last = exp_last.pop_front();
            check(out_data == e, "R5 R7 stream", out_data, e);
          end
        end
        if (crc_done) busy = 1'b0;
      end
    end
  end

  task automatic send(input logic [7:0] d, input bit p);
    bit hs = 1'b0;
    in_valid = 1'b1; in_data = d; in_pad = p;
    while (!hs) begin
      #5; hs = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
    exp_q.push_back(d); exp_last.push_back(1'b0);
    if (!p) pkt.push_back(d);
  endtask

  task automatic end_pkt(input bit stray);
    logic [31:0] c;
    c = ref_crc(pkt);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(c[31-8*k -: 8]);
      exp_last.push_back(k == 3);
    end
    trailer_done = 1'b1;
    @(negedge clk);
    trailer_done = 1'b0;
    busy = 1'b1;
    n_pkts++;
    if (stray) begin   // R10: pulse during drain or append
      @(negedge clk); trailer_done = 1'b1;
      @(negedge clk); trailer_done = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    pkt.delete();
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_pad = 1'b0;
    trailer_done = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    check(!out_valid, "R11 out_valid", out_valid, 0);
    check(in_ready, "R11 in_ready", in_ready, 1);
    check(!crc_done, "R11 crc_done", crc_done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: nothing leaves until four bytes are held
    send(8'h11, 0); send(8'h22, 0); send(8'h33, 0);
    #5; check(!out_valid, "R2 three held", out_valid, 0);
    @(negedge clk);
    send(8'h44, 0);
    #5; check(out_valid, "R2 four held", out_valid, 1);
    @(negedge clk);
    end_pkt(0);

    // R4: check value of "123456789"
    for (int i = 0; i < 9; i++) send(8'h31 + 8'(i), 0);
    end_pkt(0);
    check(last_word == 32'hFC891918, "R4 check value", last_word, 32'hFC891918);

    // R9: empty packet, then all-padding packet
    end_pkt(0);
    check(last_word == 32'h0, "R9 empty packet", last_word, 0);
    for (int i = 0; i < 6; i++) send(8'hA0 + 8'(i), 1);
    end_pkt(0);
    check(last_word == 32'h0, "R9 all padding", last_word, 0);

    // R5: padding mixed in must not change the checksum
    for (int i = 0; i < 9; i++) begin
      send(8'h31 + 8'(i), 0);
      if (i == 4) begin send(8'h00, 1); send(8'hFF, 1); end
    end
    end_pkt(0);
    check(last_word == 32'hFC891918, "R5 pad skipped", last_word, 32'hFC891918);

    // R7 short packet with stray trailer_done (R10)
    send(8'h5A, 0); send(8'hC3, 1);
    end_pkt(1);

    // R1: long output stall in mid-packet
    rand_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (i == 5) fork begin
        rand_ready = 1'b0; out_ready = 1'b0;
        repeat (10) @(negedge clk);
        rand_ready = 1'b1;
      end join_none
      send(8'(i * 17), (i % 5) == 3);
    end
    end_pkt(1);

    // Random packets with gaps and back-pressure
    for (int p = 0; p < 40; p++) begin
      int len;
      len = $urandom % 40;
      for (int i = 0; i < len; i++) begin
        send(8'($urandom), ($urandom % 4) == 0);
        repeat ($urandom % 3) @(negedge clk);
      end
      end_pkt(($urandom % 3) == 0);
    end

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R10 stream complete", exp_q.size(), 0);
    check(n_done == n_pkts, "R8 done count", n_done, n_pkts);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", n_done, n_pkts);
      summary();
      $finish;
    end
  end

endmodule